// File: doc/BRIEF.md
# Translation Lookaside Buffer with Invalidation

This block is a small fully associative cache of address translations. It sits in front of the page table walker and keeps recently used virtual-page to physical-frame pairs, so that most memory accesses never walk the tables. Each lookup is answered in the same cycle with a hit flag, the frame number and the two permission bits (write allowed, user allowed). A hit still checks permissions: a store to a read-only page, or a user access to a supervisor page, raises a protection fault flag even though the translation was found.

When a lookup misses, the walker resolves the translation and the result is written into the buffer by hardware through the fill port. Walks that ended in a fault are marked as such on the fill port and are not cached. Two kinds of invalidation exist. Writing the page directory base register drops every entry, and a targeted invalidate removes only the entry for one virtual page. When an invalidation and a fill arrive together, the invalidation acts first and the fill is then written, so a fill of the same page installs fresh contents.

A fill goes to the entry that already holds the same page, if any. Otherwise it goes to the lowest-numbered free entry, and otherwise to the entry named by a round-robin pointer, which then steps forward.

Top module: `tlb_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid, every lookup misses, and the round-robin pointer is at entry 0.
- R2: A lookup whose page number matches a valid entry gives `lk_hit`=1 and that entry's frame, write bit and user bit in the same cycle. On a miss, `lk_hit`, `lk_pfn`, `lk_wr`, `lk_usr` and `lk_fault` are all 0.
- R3: `lk_fault` is 1 exactly when the lookup hits and either (`lk_is_write`=1 and the entry's write bit is 0) or (`lk_is_user`=1 and the entry's user bit is 0). It is never 1 on a miss.
- R4: A fill with `fill_faulted`=0 installs the translation, visible to lookups from the next cycle. A fill with `fill_faulted`=1 changes no entry and does not move the pointer.
- R5: A fill for a page already held by a valid entry rewrites that entry in place. No page is ever held by two entries, and the pointer does not move.
- R6: A fill for a new page goes to the lowest-index invalid entry, leaving the pointer unchanged. If all 8 entries are valid it replaces the entry at the pointer, and the pointer then advances by one, wrapping from 7 to 0.
- R7: A cycle with `pdbr_write`=1 invalidates every entry, visible from the next cycle.
- R8: A cycle with `inv_en`=1 invalidates only the entry whose page equals `inv_vpn`. All other entries keep their contents.
- R9: In a cycle that carries both an invalidation (either kind) and an accepted fill, the invalidation is applied first and entry choice for the fill sees the cleared state, so the fill of an invalidated page installs the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_is_write | input | 1 | The access is a store |
| lk_is_user | input | 1 | The access is made in user mode |
| lk_hit | output | 1 | A valid entry matches `lk_vpn` |
| lk_pfn | output | 20 | Frame number of the matching entry |
| lk_wr | output | 1 | Write-allowed bit of the matching entry |
| lk_usr | output | 1 | User-allowed bit of the matching entry |
| lk_fault | output | 1 | Protection violation on a hit |
| fill_en | input | 1 | Walker result is presented |
| fill_faulted | input | 1 | The walk ended in a fault; do not cache |
| fill_vpn | input | 20 | Page number of the walk result |
| fill_pfn | input | 20 | Frame number of the walk result |
| fill_wr | input | 1 | Write-allowed bit of the walk result |
| fill_usr | input | 1 | User-allowed bit of the walk result |
| pdbr_write | input | 1 | Page directory base was written; flush all |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The hardest state to reach is a full buffer where the round-robin pointer decides the victim, especially right after a rewrite in place or a refill of a freed slot, neither of which may move the pointer. The stimulus draws page numbers from a pool of twelve values, larger than the eight entries, so random fills keep the buffer full and force evictions, while directed sequences fill exactly eight pages, evict, rewrite a held page and free a middle slot before the next eviction. Same-cycle invalidate-plus-fill of the same page and flush-plus-fill are also driven on purpose, since random picks rarely align them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned VPN_W = 20;
    localparam int unsigned PFN_W = 20;
    localparam int unsigned N_ENT = 8;
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [N_ENT-1:0] way_vec_t;
    typedef logic [IDX_W-1:0] way_idx_t;

    typedef struct packed {
        pfn_t pfn;
        logic wr;
        logic usr;
    } xlat_t;

    typedef struct packed {
        logic  valid;
        vpn_t  vpn;
        xlat_t xl;
    } tlb_ent_t;

    typedef tlb_ent_t [N_ENT-1:0] ent_arr_t;

    // Lowest set bit as a one-hot vector (zero when none set).
    function automatic way_vec_t lowest_one(input way_vec_t v);
        way_vec_t r;
        logic     found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < int'(N_ENT); i++) begin
            if (v[i] && !found) begin
                r[i]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic perm_violation(input xlat_t x, input logic is_wr,
                                            input logic is_usr);
        return (is_wr && !x.wr) || (is_usr && !x.usr);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
(
    input  ent_arr_t ents,
    input  vpn_t     key,
    output way_vec_t match
);
    for (genvar i = 0; i < int'(N_ENT); i++) begin : g_cmp
        assign match[i] = ents[i].valid && (ents[i].vpn == key);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  way_vec_t valid_live,
    input  way_vec_t same_live,
    input  logic     take,
    output way_vec_t way_oh
);
    localparam way_idx_t LAST = way_idx_t'(N_ENT - 1);

    way_idx_t ptr;
    logic     use_rr;
    way_vec_t free_oh;
    way_vec_t rr_oh;

    assign free_oh = lowest_one(~valid_live);

    always_comb begin
        rr_oh      = '0;
        rr_oh[ptr] = 1'b1;
    end

    always_comb begin
        use_rr = 1'b0;
        if (|same_live) begin
            way_oh = same_live;
        end else if (|free_oh) begin
            way_oh = free_oh;
        end else begin
            way_oh = rr_oh;
            use_rr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take && use_rr) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(take && use_rr) |=> $stable(ptr));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && use_rr) |=> (ptr != $past(ptr)));

    // R6
    way_single_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> $onehot(way_oh));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  way_vec_t clear,
    input  way_vec_t wr_oh,
    input  vpn_t     wr_vpn,
    input  xlat_t    wr_xl,
    output ent_arr_t ents
);
    for (genvar i = 0; i < int'(N_ENT); i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else begin
                if (clear[i]) ents[i].valid <= 1'b0;
                if (wr_oh[i]) begin
                    ents[i].valid <= 1'b1;
                    ents[i].vpn   <= wr_vpn;
                    ents[i].xl    <= wr_xl;
                end
            end
        end

        // R8
        inv_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (clear[i] && !wr_oh[i]) |=> !ents[i].valid);

        // R8
        keep_chk: assert property (@(posedge clk) disable iff (rst)
            (!clear[i] && !wr_oh[i]) |=> $stable(ents[i]));
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_is_write,
    input  logic             lk_is_user,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_wr,
    output logic             lk_usr,
    output logic             lk_fault,
    input  logic             fill_en,
    input  logic             fill_faulted,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr,
    input  logic             fill_usr,
    input  logic             pdbr_write,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn
);
    ent_arr_t ents;
    way_vec_t lk_match, fill_match, inv_match;
    way_vec_t valid_now, clear, valid_live, same_live, way_oh, wr_oh;
    logic     take;
    xlat_t    lk_xl, fill_xl;

    tlb_cam u_cam_lk   (.ents(ents), .key(lk_vpn),   .match(lk_match));
    tlb_cam u_cam_fill (.ents(ents), .key(fill_vpn), .match(fill_match));
    tlb_cam u_cam_inv  (.ents(ents), .key(inv_vpn),  .match(inv_match));

    for (genvar i = 0; i < int'(N_ENT); i++) begin : g_valid
        assign valid_now[i] = ents[i].valid;
    end

    // Invalidation is resolved before fill placement.
    assign clear      = pdbr_write ? '1 : (inv_en ? inv_match : '0);
    assign valid_live = valid_now & ~clear;
    assign same_live  = fill_match & ~clear;
    assign take       = fill_en && !fill_faulted;
    assign wr_oh      = take ? way_oh : '0;
    assign fill_xl    = '{pfn: fill_pfn, wr: fill_wr, usr: fill_usr};

    tlb_victim u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_live(valid_live),
        .same_live (same_live),
        .take      (take),
        .way_oh    (way_oh)
    );

    tlb_store u_store (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .wr_oh (wr_oh),
        .wr_vpn(fill_vpn),
        .wr_xl (fill_xl),
        .ents  (ents)
    );

    always_comb begin
        lk_xl = '0;
        for (int i = 0; i < int'(N_ENT); i++) begin
            if (lk_match[i]) lk_xl = lk_xl | ents[i].xl;
        end
    end

    assign lk_hit   = |lk_match;
    assign lk_pfn   = lk_xl.pfn;
    assign lk_wr    = lk_xl.wr;
    assign lk_usr   = lk_xl.usr;
    assign lk_fault = lk_hit && perm_violation(lk_xl, lk_is_write, lk_is_user);

    // R3
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);

    // R5
    no_dup_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R7
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (pdbr_write && !take) |=> (valid_now == '0));

    // R4
    faulted_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_faulted && !pdbr_write && !inv_en) |=> $stable(ents));

    // R4
    fill_seen_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ($countones(valid_now) >= 1));
endmodule

// File: tb/tb_tlb_cache.sv
`timescale 1ns/1ps
module tb_tlb_cache;
    localparam int N = 8;
    localparam real HALF = 10.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] lk_vpn = '0;
    logic        lk_is_write = 1'b0, lk_is_user = 1'b0;
    logic        lk_hit, lk_wr, lk_usr, lk_fault;
    logic [19:0] lk_pfn;
    logic        fill_en = 1'b0, fill_faulted = 1'b0, fill_wr = 1'b0, fill_usr = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        pdbr_write = 1'b0, inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // reference model
    bit          m_v  [N];
    logic [19:0] m_vpn[N];
    logic [19:0] m_pfn[N];
    bit          m_wr [N];
    bit          m_usr[N];
    int          m_ptr;

    always #(HALF) clk = ~clk;

    tlb_cache dut (.*);

    function automatic int m_find(input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_wr[i] = 0; m_usr[i] = 0;
        end
        m_ptr = 0;
    endfunction

    function automatic void m_update();
        int idx;
        if (pdbr_write) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (inv_en) begin
            idx = m_find(inv_vpn);
            if (idx >= 0) m_v[idx] = 0;
        end
        if (fill_en && !fill_faulted) begin
            idx = m_find(fill_vpn);
            if (idx < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
            end
            if (idx < 0) begin
                idx   = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[idx] = 1; m_vpn[idx] = fill_vpn; m_pfn[idx] = fill_pfn;
            m_wr[idx] = fill_wr; m_usr[idx] = fill_usr;
        end
    endfunction

    task automatic chk1(input string tag, input logic [19:0] act, input logic [19:0] exp_v,
                        input string what);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
        end
    endtask

    task automatic check_lookup(input string tag);
        int idx;
        logic e_hit, e_wr, e_usr, e_fault;
        logic [19:0] e_pfn;
        idx = m_find(lk_vpn);
        e_hit = (idx >= 0);
        e_pfn = e_hit ? m_pfn[idx] : '0;
        e_wr  = e_hit ? m_wr[idx]  : 1'b0;
        e_usr = e_hit ? m_usr[idx] : 1'b0;
        e_fault = e_hit && ((lk_is_write && !e_wr) || (lk_is_user && !e_usr));
        chk1(tag,  20'(lk_hit), 20'(e_hit), "hit");
        chk1(tag,  lk_pfn, e_pfn, "pfn");
        chk1(tag,  20'({lk_wr, lk_usr}), 20'({e_wr, e_usr}), "perm");
        chk1("R3", 20'(lk_fault), 20'(e_fault), "fault");
    endtask

    // one cycle: drive ops and lookup, check lookup against state before the edge
    task automatic step(input string tag, input logic [19:0] lv, input bit lw, input bit lu,
                        input bit fe, input bit ff, input logic [19:0] fv, input logic [19:0] fp,
                        input bit fw, input bit fu, input bit pd, input bit ie,
                        input logic [19:0] iv);
        @(negedge clk);
        lk_vpn = lv; lk_is_write = lw; lk_is_user = lu;
        fill_en = fe; fill_faulted = ff; fill_vpn = fv; fill_pfn = fp;
        fill_wr = fw; fill_usr = fu; pdbr_write = pd; inv_en = ie; inv_vpn = iv;
        #1;
        check_lookup(tag);
        m_update();
    endtask

    task automatic look(input string tag, input logic [19:0] lv, input bit lw, input bit lu);
        step(tag, lv, lw, lu, 0, 0, '0, '0, 0, 0, 0, 0, '0);
    endtask

    task automatic fill(input logic [19:0] fv, input logic [19:0] fp, input bit fw, input bit fu);
        step("R4", '0, 0, 0, 1, 0, fv, fp, fw, fu, 0, 0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(2.0 * HALF * 200000.0);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state misses everywhere
        look("R1", 20'h00000, 0, 0);
        look("R1", 20'h00010, 1, 1);

        // R4 / R2: fill eight pages, then look each up
        for (int k = 0; k < N; k++) fill(20'h00100 + 20'(k), 20'hA0000 + 20'(k), k[0], k[1]);
        for (int k = 0; k < N; k++) look("R2", 20'h00100 + 20'(k), 0, 0);

        // R4: faulted walk is not cached
        step("R4", '0, 0, 0, 1, 1, 20'h00200, 20'hBBBBB, 1, 1, 0, 0, '0);
        look("R4", 20'h00200, 0, 0);

        // R6: full buffer evicts entry at pointer 0, then 1
        fill(20'h00200, 20'hB0000, 1, 1);
        look("R6", 20'h00100, 0, 0);
        chk1("R6", 20'(lk_hit), 20'd0, "evicted page 0x100 hit");
        look("R6", 20'h00200, 0, 0);
        fill(20'h00201, 20'hB0001, 1, 1);
        look("R6", 20'h00101, 0, 0);

        // R5: rewrite of held page in place, pointer unmoved
        fill(20'h00103, 20'hC0003, 1, 0);
        look("R5", 20'h00103, 0, 0);
        chk1("R5", lk_pfn, 20'hC0003, "rewritten pfn");
        fill(20'h00202, 20'hB0002, 1, 1);
        look("R6", 20'h00102, 0, 0);
        look("R5", 20'h00103, 0, 0);

        // R8: single invalidate
        step("R8", '0, 0, 0, 0, 0, '0, '0, 0, 0, 0, 1, 20'h00105);
        look("R8", 20'h00105, 0, 0);
        look("R8", 20'h00106, 0, 0);
        look("R8", 20'h00104, 0, 0);

        // R6: free slot taken before round robin
        fill(20'h00300, 20'hD0000, 0, 0);
        fill(20'h00301, 20'hD0001, 0, 0);
        look("R6", 20'h00103, 0, 0);
        look("R6", 20'h00300, 0, 0);

        // R9: invalidate and fill same page in one cycle
        step("R9", '0, 0, 0, 1, 0, 20'h00106, 20'hE0006, 1, 1, 0, 1, 20'h00106);
        look("R9", 20'h00106, 0, 0);
        chk1("R9", lk_pfn, 20'hE0006, "refilled pfn");

        // R3: permission faults on hits
        fill(20'h00400, 20'hF0000, 0, 0);
        look("R3", 20'h00400, 1, 0);
        look("R3", 20'h00400, 0, 1);
        look("R3", 20'h00400, 0, 0);
        look("R3", 20'h00106, 1, 1);

        // R7: flush all
        step("R7", '0, 0, 0, 0, 0, '0, '0, 0, 0, 1, 0, '0);
        look("R7", 20'h00106, 0, 0);
        look("R7", 20'h00200, 0, 0);

        // R9: flush with fill in one cycle keeps only the fill
        fill(20'h00500, 20'h11111, 1, 1);
        step("R9", '0, 0, 0, 1, 0, 20'h00501, 20'h22222, 1, 1, 1, 0, '0);
        look("R9", 20'h00500, 0, 0);
        look("R9", 20'h00501, 0, 0);

        // random traffic, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [19:0] lv, fv, iv;
            r  = int'($urandom_range(99));
            lv = 20'h00600 + 20'($urandom_range(11));
            fv = 20'h00600 + 20'($urandom_range(11));
            iv = 20'h00600 + 20'($urandom_range(11));
            step("R2", lv, 1'($urandom), 1'($urandom),
                 (r < 60) || (r >= 93 && r < 98), (r < 6),
                 fv, 20'($urandom), 1'($urandom), 1'($urandom),
                 (r >= 98), (r >= 60 && r < 70) || (r >= 93 && r < 96),
                 (r >= 93 && r < 96) ? fv : iv);
        end

        look("R2", 20'h00600, 0, 0);
        finish_run();
    end
endmodule